// File: doc/BRIEF.md
# Quick-Channel Trigger and Completion Controller

This block lets a host start a transfer simply by writing a chosen word of a parameter set. Up to eight quick channels can each be bound to one 32-byte parameter set and to one 32-bit word inside it. When the host writes that word, and the channel is enabled and idle, the block issues a one-cycle trigger. The trigger carries the channel number and the parameter-set number, and the transfer engine acts on it. If the bound word is written again before the engine reports completion on that channel, no trigger is issued. Instead the block records a missed event for the channel.

All host writes arrive on a single register port. Writes to the upper half of the address space (address bit 14 set) go to the parameter memory, which lives outside this block. The block only watches those writes to detect triggers. The lower half holds the control registers.

The transfer engine reports completion with a channel number and a 6-bit completion code. The code sets one of 64 pending bits, which software clears by writing ones. The interrupt line is high while any pending bit is set.

Top module: `qtrig_ctrl`

## Requirements
- R1: After reset, all enable, missed, busy, pending and map state is zero, every register reads zero, and `trig_valid` and `irq` are low.
- R2: Channel n has a map register at 0x200 + 4*n. The parameter-set number sits in bits 13:5 and the word index in bits 4:2. A read returns only those two fields, with all other bits zero. Writing a value whose two fields are both zero unmaps the channel, and an unmapped channel never triggers.
- R3: A host write to address 0x4000 + 32*set + 4*word, where set and word match an enabled, mapped and idle channel, makes `trig_valid` high for exactly the one cycle after the write. In that cycle `trig_chan` and `trig_set` carry the channel and its set.
- R4: Some writes have no effect on triggers or on missed state. These are writes to any other word of a mapped set, and writes that match a channel whose enable is clear.
- R5: Writing ones to 0x300 sets the matching enable bits. Writing ones to 0x304 clears them. Both addresses read the enable vector in bits 7:0.
- R6: Issuing a trigger marks the channel busy. A matching write to a busy channel issues no trigger. The busy vector reads at 0x310, and writing ones there clears busy bits. A completion report for a channel clears its busy bit, but a matching write in that same cycle still counts as a miss.
- R7: Each miss sets the channel's bit in the missed vector, which reads at 0x308. Writing ones to 0x30C clears missed bits.
- R8: A completion with code c below 32 sets bit c of the low pending word, which reads at 0x320. A code of 32 or more sets bit c-32 of the high pending word, which reads at 0x324.
- R9: Writing ones to 0x328 clears low pending bits, and writing ones to 0x32C clears high pending bits. If a completion sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: `irq` is high exactly when at least one of the 64 pending bits is set.
- R11: When one write matches several enabled channels, only the lowest-numbered idle one triggers. Every other enabled channel that matched gets its missed bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 15 | Host byte address; bit 14 selects parameter memory |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| cmpl_valid | input | 1 | Completion report strobe |
| cmpl_chan | input | 3 | Channel whose transfer completed |
| cmpl_code | input | 6 | Completion code selecting a pending bit |
| trig_valid | output | 1 | One-cycle trigger pulse |
| trig_chan | output | 3 | Channel of the trigger |
| trig_set | output | 9 | Parameter-set number of the trigger |
| irq | output | 1 | OR of all pending bits |

## Verification
The bench goes after several corner cases:
- **Neighbouring and highest addresses.** It writes a word next to the bound one and the highest parameter set. A decoder off by one word, or one with a truncated set compare, would trigger falsely or miss set 511.
- **Shared bindings.** It binds two channels to the same word and then disables one of them. Wrong arbitration would fire two triggers, pick the higher channel, or drop the missed flag of the loser.
- **Same-cycle collisions.** It drives a completion together with a pending clear on the same bit, and a completion together with a trigger write on the same channel. A design with the wrong precedence would lose a completion or accept a trigger into a busy channel.
- **Unmapping.** It checks that writing zero to a map register really disarms the channel.

// File: rtl/qtc_pkg.sv
package qtc_pkg;
    // control register byte offsets (lower half of the host space)
    localparam int unsigned MAP_BASE  = 32'h200;
    localparam int unsigned EN_SET    = 32'h300;
    localparam int unsigned EN_CLR    = 32'h304;
    localparam int unsigned MISS_RD   = 32'h308;
    localparam int unsigned MISS_CLR  = 32'h30C;
    localparam int unsigned BUSY_REG  = 32'h310;
    localparam int unsigned PEND_LO   = 32'h320;
    localparam int unsigned PEND_HI   = 32'h324;
    localparam int unsigned PCLR_LO   = 32'h328;
    localparam int unsigned PCLR_HI   = 32'h32C;
    // byte offset of the word index inside a parameter set
    localparam int unsigned WORD_LSB  = 2;
    localparam int unsigned SET_LSB   = 5;
endpackage

// File: rtl/qtc_map_reg.sv
module qtc_map_reg #(
    parameter int SET_W  = 9,
    parameter int WORD_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SET_W+WORD_W-1:0]   wr_field,
    input  logic                      pw_valid,
    input  logic [SET_W-1:0]          pw_set,
    input  logic [WORD_W-1:0]         pw_word,
    output logic                      hit,
    output logic [SET_W-1:0]          map_set,
    output logic [DATA_W-1:0]         map_rdata
);
    typedef struct packed {
        logic              mapped;
        logic [SET_W-1:0]  set;
        logic [WORD_W-1:0] word;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.set    = wr_field[SET_W+WORD_W-1:WORD_W];
            st_d.word   = wr_field[WORD_W-1:0];
            st_d.mapped = |wr_field;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit       = pw_valid && st_q.mapped && (st_q.set == pw_set) && (st_q.word == pw_word);
    assign map_set   = st_q.set;
    assign map_rdata = DATA_W'({st_q.set, st_q.word, 2'b00});
endmodule

// File: rtl/qtc_trig.sv
module qtc_trig #(
    parameter int NUM_CH = 8,
    parameter int SET_W  = 9,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       hit,
    input  logic [NUM_CH*SET_W-1:0] sets_flat,
    input  logic [NUM_CH-1:0]       wmask,
    input  logic                    en_set_we,
    input  logic                    en_clr_we,
    input  logic                    miss_clr_we,
    input  logic                    busy_clr_we,
    input  logic                    cmpl_valid,
    input  logic [CH_W-1:0]         cmpl_chan,
    output logic [NUM_CH-1:0]       en,
    output logic [NUM_CH-1:0]       miss,
    output logic [NUM_CH-1:0]       busy,
    output logic                    trig_valid,
    output logic [CH_W-1:0]         trig_chan,
    output logic [SET_W-1:0]        trig_set
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] miss;
        logic [NUM_CH-1:0] busy;
        logic              tv;
        logic [CH_W-1:0]   tc;
        logic [SET_W-1:0]  ts;
    } trig_t;

    trig_t             st_d, st_q;
    logic [NUM_CH-1:0] cand, win, cmask;
    logic              found;
    logic [CH_W-1:0]   idx;

    always_comb begin
        st_d  = st_q;
        cand  = hit & st_q.en;
        found = 1'b0;
        idx   = '0;
        // descending scan so the lowest idle candidate is kept
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i] && !st_q.busy[i]) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
        win   = found ? (NUM_CH'(1) << idx) : '0;
        cmask = cmpl_valid ? (NUM_CH'(1) << cmpl_chan) : '0;

        st_d.en   = (st_q.en | (en_set_we ? wmask : '0)) & ~(en_clr_we ? wmask : '0);
        st_d.miss = (st_q.miss & ~(miss_clr_we ? wmask : '0)) | (cand & ~win);
        st_d.busy = (st_q.busy & ~(busy_clr_we ? wmask : '0) & ~cmask) | win;
        st_d.tv   = found;
        st_d.tc   = idx;
        st_d.ts   = sets_flat[idx*SET_W +: SET_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en         = st_q.en;
    assign miss       = st_q.miss;
    assign busy       = st_q.busy;
    assign trig_valid = st_q.tv;
    assign trig_chan  = st_q.tc;
    assign trig_set   = st_q.ts;

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.busy & ~$past(st_q.busy)) != '0) |-> st_q.tv);
    // R3
    trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tv |-> st_q.busy[st_q.tc]);
    // R7
    miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.miss & ~$past(st_q.miss)) != '0) |-> $past(|hit));
endmodule

// File: rtl/qtc_pend.sv
module qtc_pend #(
    parameter int CODE_W = 6,
    localparam int NBITS = 1 << CODE_W,
    localparam int HALF  = NBITS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid,
    input  logic [CODE_W-1:0] done_code,
    input  logic              clr_lo_we,
    input  logic              clr_hi_we,
    input  logic [HALF-1:0]   clr_mask,
    output logic [NBITS-1:0]  pend
);
    logic [NBITS-1:0] pend_d, pend_q, set_v, clr_v;

    always_comb begin
        set_v  = done_valid ? (NBITS'(1) << done_code) : '0;
        clr_v  = {(clr_hi_we ? clr_mask : '0), (clr_lo_we ? clr_mask : '0)};
        pend_d = (pend_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> pend_q[$past(done_code)]);
    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo_we && clr_mask[0] && !(done_valid && done_code == '0)) |=> !pend_q[0]);
endmodule

// File: rtl/qtrig_ctrl.sv
module qtrig_ctrl
    import qtc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SET_W  = 9,
    parameter int WORD_W = 3,
    parameter int CODE_W = 6,
    parameter int DATA_W = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = SET_W + SET_LSB + 1,
    localparam int HALF   = (1 << CODE_W) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cmpl_valid,
    input  logic [CH_W-1:0]   cmpl_chan,
    input  logic [CODE_W-1:0] cmpl_code,
    output logic              trig_valid,
    output logic [CH_W-1:0]   trig_chan,
    output logic [SET_W-1:0]  trig_set,
    output logic              irq
);
    logic                    pw_valid, reg_we;
    logic [SET_W-1:0]        pw_set;
    logic [WORD_W-1:0]       pw_word;
    logic [NUM_CH-1:0]       hit, en, miss, busy;
    logic [NUM_CH*SET_W-1:0] sets_flat;
    logic [DATA_W-1:0]       map_rd [NUM_CH];
    logic [2*HALF-1:0]       pend;

    assign pw_valid = host_we && host_addr[ADDR_W-1];
    assign reg_we   = host_we && !host_addr[ADDR_W-1];
    assign pw_set   = host_addr[SET_LSB +: SET_W];
    assign pw_word  = host_addr[WORD_LSB +: WORD_W];

    function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    for (genvar g = 0; g < NUM_CH; g++) begin : g_map
        qtc_map_reg #(.SET_W(SET_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && at(host_addr, MAP_BASE + 4 * g)),
            .wr_field (host_wdata[WORD_LSB +: SET_W + WORD_W]),
            .pw_valid (pw_valid),
            .pw_set   (pw_set),
            .pw_word  (pw_word),
            .hit      (hit[g]),
            .map_set  (sets_flat[g*SET_W +: SET_W]),
            .map_rdata(map_rd[g])
        );
    end

    qtc_trig #(.NUM_CH(NUM_CH), .SET_W(SET_W)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .sets_flat  (sets_flat),
        .wmask      (host_wdata[NUM_CH-1:0]),
        .en_set_we  (reg_we && at(host_addr, EN_SET)),
        .en_clr_we  (reg_we && at(host_addr, EN_CLR)),
        .miss_clr_we(reg_we && at(host_addr, MISS_CLR)),
        .busy_clr_we(reg_we && at(host_addr, BUSY_REG)),
        .cmpl_valid (cmpl_valid),
        .cmpl_chan  (cmpl_chan),
        .en         (en),
        .miss       (miss),
        .busy       (busy),
        .trig_valid (trig_valid),
        .trig_chan  (trig_chan),
        .trig_set   (trig_set)
    );

    qtc_pend #(.CODE_W(CODE_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_valid(cmpl_valid),
        .done_code (cmpl_code),
        .clr_lo_we (reg_we && at(host_addr, PCLR_LO)),
        .clr_hi_we (reg_we && at(host_addr, PCLR_HI)),
        .clr_mask  (host_wdata[HALF-1:0]),
        .pend      (pend)
    );

    assign irq = |pend;

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (at(host_addr, MAP_BASE + 4 * i)) host_rdata = map_rd[i];
        end
        if (at(host_addr, EN_SET) || at(host_addr, EN_CLR)) host_rdata = DATA_W'(en);
        if (at(host_addr, MISS_RD))  host_rdata = DATA_W'(miss);
        if (at(host_addr, BUSY_REG)) host_rdata = DATA_W'(busy);
        if (at(host_addr, PEND_LO))  host_rdata = DATA_W'(pend[HALF-1:0]);
        if (at(host_addr, PEND_HI))  host_rdata = DATA_W'(pend[2*HALF-1:HALF]);
    end

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmpl_valid));
endmodule

// File: tb/qtrig_ctrl_test.sv
`timescale 1ns/1ps
module qtrig_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cmpl_valid = 1'b0;
    logic [2:0]  cmpl_chan = '0;
    logic [5:0]  cmpl_code = '0;
    logic        trig_valid;
    logic [2:0]  trig_chan;
    logic [8:0]  trig_set;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    qtrig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmpl_valid(cmpl_valid),
        .cmpl_chan(cmpl_chan), .cmpl_code(cmpl_code), .trig_valid(trig_valid),
        .trig_chan(trig_chan), .trig_set(trig_set), .irq(irq)
    );

    // op: 0 read-check, 1 register write, 2 parameter write + trigger check, 3 completion
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    // trigger expectation: bit 12 valid, bits 11:9 channel, bits 8:0 set; completion data: bits 8:6 channel, 5:0 code
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0300, 32'h0,        32'h0,      4'd1},  // R1 enable
        '{2'd0, 16'h0320, 32'h0,        32'h0,      4'd1},  // R1 pending
        '{2'd0, 16'h0200, 32'h0,        32'h0,      4'd1},  // R1 map
        '{2'd1, 16'h0200, 32'hFFFFFFFF, 32'h0,      4'd2},
        '{2'd0, 16'h0200, 32'h0,        32'h3FFC,   4'd2},  // R2 fields only
        '{2'd1, 16'h0200, 32'h000000BC, 32'h0,      4'd2},  // ch0 -> set 5 word 7
        '{2'd2, 16'h40BC, 32'h1,        32'h0,      4'd4},  // R4 disabled
        '{2'd1, 16'h0300, 32'h01,       32'h0,      4'd5},
        '{2'd0, 16'h0300, 32'h0,        32'h01,     4'd5},  // R5
        '{2'd2, 16'h40B8, 32'h1,        32'h0,      4'd4},  // R4 other word
        '{2'd2, 16'h40BC, 32'h1,        32'h1005,   4'd3},  // R3
        '{2'd0, 16'h0310, 32'h0,        32'h01,     4'd6},  // R6 busy
        '{2'd2, 16'h40BC, 32'h1,        32'h0,      4'd6},  // R6 busy blocks
        '{2'd0, 16'h0308, 32'h0,        32'h01,     4'd7},  // R7
        '{2'd1, 16'h030C, 32'h01,       32'h0,      4'd7},
        '{2'd0, 16'h0308, 32'h0,        32'h0,      4'd7},  // R7 cleared
        '{2'd3, 16'h0000, 32'h003,      32'h0,      4'd8},
        '{2'd0, 16'h0310, 32'h0,        32'h0,      4'd6},  // R6 completion frees
        '{2'd0, 16'h0320, 32'h0,        32'h8,      4'd8},  // R8 low
        '{2'd3, 16'h0000, 32'h028,      32'h0,      4'd8},
        '{2'd0, 16'h0324, 32'h0,        32'h100,    4'd8},  // R8 high
        '{2'd1, 16'h0328, 32'h8,        32'h0,      4'd9},
        '{2'd0, 16'h0320, 32'h0,        32'h0,      4'd9},  // R9
        '{2'd0, 16'h0324, 32'h0,        32'h100,    4'd9},  // R9 high untouched
        '{2'd1, 16'h032C, 32'h100,      32'h0,      4'd9},
        '{2'd0, 16'h0324, 32'h0,        32'h0,      4'd9},  // R9
        '{2'd1, 16'h020C, 32'h3FE0,     32'h0,      4'd3},  // ch3 -> set 511 word 0
        '{2'd1, 16'h0300, 32'h08,       32'h0,      4'd5},
        '{2'd0, 16'h0300, 32'h0,        32'h09,     4'd5},  // R5 set is additive
        '{2'd2, 16'h7FE0, 32'h1,        32'h17FF,   4'd3},  // R3 top set
        '{2'd0, 16'h0310, 32'h0,        32'h08,     4'd6},  // R6
        '{2'd1, 16'h0310, 32'h08,       32'h0,      4'd6},
        '{2'd0, 16'h0310, 32'h0,        32'h0,      4'd6},  // R6 busy clear
        '{2'd1, 16'h0214, 32'h000000BC, 32'h0,      4'd11}, // ch5 shares ch0 word
        '{2'd1, 16'h0300, 32'h20,       32'h0,      4'd11},
        '{2'd2, 16'h40BC, 32'h1,        32'h1005,   4'd11}, // R11 lowest wins
        '{2'd0, 16'h0308, 32'h0,        32'h20,     4'd11}, // R11 loser missed
        '{2'd1, 16'h0304, 32'h01,       32'h0,      4'd5},
        '{2'd0, 16'h0300, 32'h0,        32'h28,     4'd5},  // R5 clear
        '{2'd1, 16'h0310, 32'h01,       32'h0,      4'd6},
        '{2'd2, 16'h40BC, 32'h1,        32'h1A05,   4'd11}, // R11 ch5 now
        '{2'd1, 16'h0214, 32'h0,        32'h0,      4'd2},
        '{2'd0, 16'h0214, 32'h0,        32'h0,      4'd2},  // R2 unmapped
        '{2'd1, 16'h0310, 32'h20,       32'h0,      4'd2},
        '{2'd2, 16'h40BC, 32'h1,        32'h0,      4'd2},  // R2 unmapped silent
        '{2'd0, 16'h0308, 32'h0,        32'h20,     4'd4}   // R4 missed unchanged
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [14:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [14:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic complete(input logic [2:0] ch, input logic [5:0] code);
        @(negedge clk);
        cmpl_valid = 1'b1; cmpl_chan = ch; cmpl_code = code;
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    function automatic logic [31:0] trig_word();
        return trig_valid ? {19'b0, 1'b1, trig_chan, trig_set} : 32'h0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 trig_valid", {31'b0, trig_valid}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
            case (VECS[i].op)
                2'd0: begin hread(VECS[i].addr[14:0], rd); check(tag, rd, VECS[i].exp); end
                2'd1: hwrite(VECS[i].addr[14:0], VECS[i].data);
                2'd2: begin hwrite(VECS[i].addr[14:0], VECS[i].data); check(tag, trig_word(), VECS[i].exp); end
                default: complete(VECS[i].data[8:6], VECS[i].data[5:0]);
            endcase
        end

        // R3 the trigger lasts one cycle only
        hwrite(15'h7FE0, 32'h1);   // ch3 idle (busy cleared earlier)
        check("R3 pulse", trig_word(), 32'h17FF);
        @(negedge clk);
        check("R3 one cycle", trig_word(), 32'h0);

        // R6 completion and matching write in one cycle: miss, no trigger, busy freed
        @(negedge clk);
        host_we = 1'b1; host_addr = 15'h7FE0; host_wdata = 32'h1;
        cmpl_valid = 1'b1; cmpl_chan = 3'd3; cmpl_code = 6'd1;
        @(negedge clk);
        host_we = 1'b0; cmpl_valid = 1'b0;
        check("R6 collide trig", trig_word(), 32'h0);
        hread(15'h308, rd); check("R6 collide missed", rd, 32'h28);
        hread(15'h310, rd); check("R6 collide busy", rd, 32'h0);
        check("R10 irq set", {31'b0, irq}, 32'h1);

        // R9 set and clear of the same bit in one cycle: set wins
        @(negedge clk);
        host_we = 1'b1; host_addr = 15'h328; host_wdata = 32'h3;
        cmpl_valid = 1'b1; cmpl_chan = 3'd0; cmpl_code = 6'd0;
        @(negedge clk);
        host_we = 1'b0; cmpl_valid = 1'b0;
        hread(15'h320, rd); check("R9 set wins", rd, 32'h1);
        check("R10 irq held", {31'b0, irq}, 32'h1);
        hwrite(15'h328, 32'h1);
        hread(15'h320, rd); check("R9 final clear", rd, 32'h0);
        check("R10 irq low", {31'b0, irq}, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule